// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block watches the stream of data accesses that a core makes and raises a one-cycle debug event when an access satisfies a programmed watchpoint. Each access presents its virtual address, whether it is a load or a store, whether it runs privileged, its size, a valid strobe and the context ID in force. The watchpoint is set up through a simple register write port. One value register holds the watched word address. One control register selects enable, the privilege and load/store qualifiers, a byte-lane mask, and an optional link to one of a small bank of context-ID comparators. Each comparator in the bank has its own value and enable.

An access raises the event only when all of these hold: the word address matches, every qualifier in the control register admits the access, at least one byte it touches is selected, the watchpoint is enabled, and, when a link is set, the linked comparator is enabled and holds the current context ID. The event is registered and appears on the clock edge after the access. Register writes are visible to the access that follows the write. An access in the same cycle as a write is judged against the old settings.

Top module: `wpm_unit`

## Requirements
- R1: The address comparison uses bits ADDR_W-1 down to 2 of the access address and of the watch value register (select 0). Bits 1:0 take no part in it.
- R2: Bit 0 of the control register (select 1) enables the watchpoint. While it is 0, no access raises the event.
- R3: Control bits 2:1 qualify privilege. Bit 1 admits privileged accesses (acc_priv=1) and bit 2 admits user accesses. 01 means privileged only, 10 means user only, 11 means either, and 00 admits nothing.
- R4: Control bits 4:3 qualify direction. Bit 3 admits loads (acc_store=0) and bit 4 admits stores. 01 means loads only, 10 means stores only, 11 means both, and 00 admits nothing.
- R5: Control bits 8:5 are a byte-lane mask, where bit 5+k selects byte lane k of the word. The lanes an access touches come from acc_size (0 byte: lane acc_addr[1:0]; 1 halfword: lanes 1:0 when acc_addr[1]=0, lanes 3:2 otherwise; 2 or 3 word: all four lanes). The event needs at least one touched lane that the mask selects.
- R6: When control bit 20 is set, bits 19:16 name a context comparator k. Comparator k's value is written at select 2+2k and its enable (bit 0) at select 3+2k. The event then also needs that comparator enabled and its value equal to acc_ctx. An index of NUM_CTX or more never matches.
- R7: When control bit 20 is clear, acc_ctx and the comparator bank have no effect on the event.
- R8: wp_hit is registered. It is high for exactly the one cycle after each qualifying access with acc_valid high, and low after any cycle with acc_valid low.
- R9: A register write takes effect from the next cycle. An access in the same cycle as a write is judged against the values held before the write.
- R10: After reset, all registers read as zero (watchpoint disabled) and wp_hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select: 0 value, 1 control, 2+2k comparator k value, 3+2k comparator k enable |
| wr_data | input | DATA_W | Register write data |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | ADDR_W | Data virtual address |
| acc_store | input | 1 | 1 store, 0 load |
| acc_priv | input | 1 | 1 privileged, 0 user |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_ctx | input | CTX_W | Current context ID |
| wp_hit | output | 1 | Watchpoint event, one cycle per matching access |

## Verification
The bench builds the unit with a 32-bit address, an 8-bit context ID and three context comparators. With three comparators, the bench can link to a comparator other than the first, and it can program link indices of 3 and above. These indices lie past the end of the bank but still fit the 4-bit index field, so the never-match rule for them can be checked. The full 32-bit address lets the bench move a single word-address bit, and also vary the low two bits alone, to separate the word compare from the byte-lane mask.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

  // Control register field positions
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_PRIV_LO  = 1;
  localparam int CTL_LS_LO    = 3;
  localparam int CTL_BAS_LO   = 5;
  localparam int CTL_IDX_LO   = 16;
  localparam int CTL_LINK_BIT = 20;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic       link;
    logic [3:0] idx;
    logic [3:0] bas;
    logic [1:0] ls;    // [0] loads, [1] stores
    logic [1:0] priv;  // [0] privileged, [1] user
    logic       en;
  } wctl_t;

  function automatic wctl_t ctl_unpack(input logic [31:0] d);
    wctl_t c;
    c.en   = d[CTL_EN_BIT];
    c.priv = d[CTL_PRIV_LO +: 2];
    c.ls   = d[CTL_LS_LO +: 2];
    c.bas  = d[CTL_BAS_LO +: 4];
    c.idx  = d[CTL_IDX_LO +: 4];
    c.link = d[CTL_LINK_BIT];
    return c;
  endfunction

endpackage

// File: rtl/wpm_regs.sv
module wpm_regs
  import wpm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CTX_W   = 8,
  parameter int NUM_CTX = 2,
  parameter int SEL_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [ADDR_W-1:0]              wval,
  output wctl_t                          wctl,
  output logic [NUM_CTX-1:0][CTX_W-1:0]  ctx_val,
  output logic [NUM_CTX-1:0]             ctx_en
);

  localparam logic [SEL_W-1:0] SEL_VAL = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_CTL = SEL_W'(1);

  // Next-state: write enables and data
  logic              wval_we, wctl_we;
  logic [ADDR_W-1:0] wval_d;
  wctl_t             wctl_d;
  logic [31:0]       ctl_word;

  always_comb begin
    ctl_word = '0;
    ctl_word[DATA_W-1:0] = wr_data;
    wval_we  = wr_en && (wr_sel == SEL_VAL);
    wctl_we  = wr_en && (wr_sel == SEL_CTL);
    wval_d   = wr_data[ADDR_W-1:0];
    wctl_d   = ctl_unpack(ctl_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wval <= '0;
    else if (wval_we) wval <= wval_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wctl <= '0;
    else if (wctl_we) wctl <= wctl_d;
  end

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
    localparam logic [SEL_W-1:0] SEL_CV = SEL_W'(2 + 2*k);
    localparam logic [SEL_W-1:0] SEL_CE = SEL_W'(3 + 2*k);
    logic cv_we, ce_we;

    always_comb begin
      cv_we = wr_en && (wr_sel == SEL_CV);
      ce_we = wr_en && (wr_sel == SEL_CE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctx_val[k] <= '0;
      else if (cv_we) ctx_val[k] <= wr_data[CTX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctx_en[k] <= 1'b0;
      else if (ce_we) ctx_en[k] <= wr_data[0];
    end

    // R9: a comparator value only changes on its own write
    p_ctx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_CV) |=> $stable(ctx_val[k]));
  end

  // R9: write visible on the following cycle, not before
  p_val_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_VAL) |=> (wval == $past(wr_data[ADDR_W-1:0])));

  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_CTL) |=> $stable(wctl));

endmodule

// File: rtl/wpm_lane_decode.sv
module wpm_lane_decode
  import wpm_pkg::*;
(
  input  logic [1:0] offset,
  input  logic [1:0] size,
  output logic [3:0] lanes
);

  acc_size_e sz;

  always_comb begin
    sz = acc_size_e'(size);
    unique case (sz)
      SZ_BYTE: lanes = 4'b0001 << offset;
      SZ_HALF: lanes = offset[1] ? 4'b1100 : 4'b0011;
      default: lanes = 4'b1111;
    endcase
  end

endmodule

// File: rtl/wpm_ctx_cmp.sv
module wpm_ctx_cmp #(
  parameter int CTX_W = 8
) (
  input  logic             en,
  input  logic [CTX_W-1:0] val,
  input  logic [CTX_W-1:0] cur,
  output logic             hit
);

  always_comb hit = en && (val == cur);

endmodule

// File: rtl/wpm_unit.sv
module wpm_unit
  import wpm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CTX_W   = 8,
  parameter int NUM_CTX = 2,
  parameter int SEL_W   = $clog2(2 + 2*NUM_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic              acc_priv,
  input  logic [1:0]        acc_size,
  input  logic [CTX_W-1:0]  acc_ctx,
  output logic              wp_hit
);

  localparam logic [4:0] NCTX5 = 5'(NUM_CTX);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  // Programmable state
  logic [ADDR_W-1:0]             wval;
  wctl_t                         wctl;
  logic [NUM_CTX-1:0][CTX_W-1:0] ctx_val;
  logic [NUM_CTX-1:0]            ctx_en;

  wpm_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTX_W  (CTX_W),
    .NUM_CTX(NUM_CTX),
    .SEL_W  (SEL_W)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .wval   (wval),
    .wctl   (wctl),
    .ctx_val(ctx_val),
    .ctx_en (ctx_en)
  );

  // Byte lanes touched by the access
  logic [3:0] lanes;

  wpm_lane_decode lanes_i (
    .offset(acc_addr[1:0]),
    .size  (acc_size),
    .lanes (lanes)
  );

  // Context comparator bank
  logic [NUM_CTX-1:0] ctx_hit;

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_cmp
    wpm_ctx_cmp #(.CTX_W(CTX_W)) cmp_i (
      .en (ctx_en[k]),
      .val(ctx_val[k]),
      .cur(acc_ctx),
      .hit(ctx_hit[k])
    );
  end

  // Condition evaluation
  logic addr_ok, priv_ok, ls_ok, lane_ok, link_sel_hit, ctx_ok, match, hit_d;

  always_comb begin
    link_sel_hit = 1'b0;
    for (int k = 0; k < NUM_CTX; k++) begin
      if (wctl.idx == 4'(k)) link_sel_hit = ctx_hit[k];
    end
    addr_ok = (acc_addr[ADDR_W-1:2] == wval[ADDR_W-1:2]);
    priv_ok = acc_priv  ? wctl.priv[0] : wctl.priv[1];
    ls_ok   = acc_store ? wctl.ls[1]   : wctl.ls[0];
    lane_ok = |(wctl.bas & lanes);
    ctx_ok  = !wctl.link || link_sel_hit;
    match   = wctl.en && addr_ok && priv_ok && ls_ok && lane_ok && ctx_ok;
    hit_d   = acc_valid && match;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) wp_hit <= 1'b0;
    else            wp_hit <= hit_d;
  end

  // Assertions
  p_idle_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !acc_valid |=> !wp_hit);

  p_disabled_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (acc_valid && !wctl.en) |=> !wp_hit);

  p_priv_none_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (acc_valid && wctl.priv == 2'b00) |=> !wp_hit);

  p_ls_none_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (acc_valid && wctl.ls == 2'b00) |=> !wp_hit);

  p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (acc_valid && acc_size == 2'd0) |-> $countones(lanes) == 1);

  p_link_range_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (acc_valid && wctl.link && ({1'b0, wctl.idx} >= NCTX5)) |=> !wp_hit);

  p_addr_word_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    wp_hit |-> ($past(acc_addr[ADDR_W-1:2]) == $past(wval[ADDR_W-1:2])));

endmodule

// File: tb/wpm_unit_tb_top.sv
module wpm_unit_tb_top;

  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int CTX_W   = 8;
  localparam int NUM_CTX = 3;
  localparam int SEL_W   = $clog2(2 + 2*NUM_CTX);

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              wr_en = 1'b0;
  logic [SEL_W-1:0]  wr_sel = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              acc_store = 1'b0;
  logic              acc_priv = 1'b0;
  logic [1:0]        acc_size = '0;
  logic [CTX_W-1:0]  acc_ctx = '0;
  logic              wp_hit;

  always #10 clk = ~clk;  // 50 MHz

  wpm_unit #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTX_W  (CTX_W),
    .NUM_CTX(NUM_CTX)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .acc_valid(acc_valid),
    .acc_addr (acc_addr),
    .acc_store(acc_store),
    .acc_priv (acc_priv),
    .acc_size (acc_size),
    .acc_ctx  (acc_ctx),
    .wp_hit   (wp_hit)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    bit    exp;
    string req;
  } item_t;
  item_t q[$];

  // Shadow of programmed state
  logic [31:0]      s_wval = '0;
  logic [31:0]      s_wctl = '0;
  logic [CTX_W-1:0] s_cval [NUM_CTX];
  bit               s_cen  [NUM_CTX];

  function automatic bit model(input logic [31:0] a, input bit st, input bit pr,
                               input logic [1:0] sz, input logic [CTX_W-1:0] cx);
    logic [3:0] ln, bas;
    bit a_ok, p_ok, l_ok, c_ok;
    int idx;
    case (sz)
      2'd0:    ln = 4'b0001 << a[1:0];
      2'd1:    ln = a[1] ? 4'b1100 : 4'b0011;
      default: ln = 4'b1111;
    endcase
    bas  = s_wctl[8:5];
    a_ok = (a[31:2] == s_wval[31:2]);
    p_ok = pr ? s_wctl[1] : s_wctl[2];
    l_ok = st ? s_wctl[4] : s_wctl[3];
    idx  = int'(s_wctl[19:16]);
    c_ok = !s_wctl[20] || (idx < NUM_CTX && s_cen[idx] && s_cval[idx] == cx);
    return s_wctl[0] && a_ok && p_ok && l_ok && |(bas & ln) && c_ok;
  endfunction

  task automatic compare(input bit act, input bit exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: wp_hit=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input bit v, input logic [31:0] a, input bit st, input bit pr,
                      input logic [1:0] sz, input logic [CTX_W-1:0] cx,
                      input bit we, input int sel, input logic [31:0] d,
                      input string req);
    item_t it;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_store = st; acc_priv = pr;
    acc_size = sz; acc_ctx = cx;
    wr_en = we; wr_sel = SEL_W'(sel); wr_data = d;
    it.exp = v && model(a, st, pr, sz, cx);
    it.req = req;
    q.push_back(it);
    if (we) begin
      if (sel == 0) s_wval = d;
      else if (sel == 1) s_wctl = d;
      else if (sel % 2 == 0) s_cval[(sel-2)/2] = d[CTX_W-1:0];
      else s_cen[(sel-3)/2] = d[0];
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d, input string req);
    step(0, 32'h0, 0, 0, 2'd0, '0, 1, sel, d, req);
  endtask

  task automatic acc(input logic [31:0] a, input bit st, input bit pr,
                     input logic [1:0] sz, input logic [CTX_W-1:0] cx, input string req);
    step(1, a, st, pr, sz, cx, 0, 0, 32'h0, req);
  endtask

  // Monitor: pop at the edge, compare half a cycle later
  item_t cur;
  bit    have = 0;
  always @(posedge clk) begin
    have = 0;
    if (q.size() > 0) begin
      cur  = q.pop_front();
      have = 1;
    end
  end
  always @(negedge clk) if (have) compare(wp_hit, cur.exp, cur.req);

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  localparam logic [31:0] WA = 32'h1000_0040;

  initial begin
    for (int k = 0; k < NUM_CTX; k++) begin s_cval[k] = '0; s_cen[k] = 0; end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare(wp_hit, 1'b0, "R10 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(wp_hit, 1'b0, "R10 after reset");

    // R10: registers zero, so a word access at address 0 does not hit
    acc(32'h0, 0, 1, 2'd2, '0, "R10 cleared regs");

    wr(0, WA, "R1 setup");
    wr(1, 32'h0000_01FF, "R1 setup");
    acc(WA, 0, 1, 2'd2, '0, "R1 word match");
    acc(WA + 4, 0, 1, 2'd2, '0, "R1 next word");
    acc(WA ^ 32'h0001_0000, 0, 1, 2'd2, '0, "R1 high bit differs");
    acc(WA + 3, 0, 1, 2'd0, '0, "R1 low bits ignored");

    wr(1, 32'h0000_01FE, "R2 setup");
    acc(WA, 0, 1, 2'd2, '0, "R2 disabled");

    wr(1, 32'h0000_01FB, "R3 setup");
    acc(WA, 0, 0, 2'd2, '0, "R3 priv-only user");
    acc(WA, 0, 1, 2'd2, '0, "R3 priv-only priv");
    wr(1, 32'h0000_01FD, "R3 setup");
    acc(WA, 0, 0, 2'd2, '0, "R3 user-only user");
    acc(WA, 0, 1, 2'd2, '0, "R3 user-only priv");
    wr(1, 32'h0000_01F9, "R3 setup");
    acc(WA, 0, 1, 2'd2, '0, "R3 none");

    wr(1, 32'h0000_01EF, "R4 setup");
    acc(WA, 1, 1, 2'd2, '0, "R4 load-only store");
    acc(WA, 0, 1, 2'd2, '0, "R4 load-only load");
    wr(1, 32'h0000_01F7, "R4 setup");
    acc(WA, 1, 1, 2'd2, '0, "R4 store-only store");
    acc(WA, 0, 1, 2'd2, '0, "R4 store-only load");
    wr(1, 32'h0000_01E7, "R4 setup");
    acc(WA, 1, 1, 2'd2, '0, "R4 none");

    wr(1, 32'h0000_003F, "R5 setup");
    acc(WA, 0, 1, 2'd0, '0, "R5 byte lane0");
    acc(WA + 2, 0, 1, 2'd0, '0, "R5 byte lane2");
    acc(WA + 2, 0, 1, 2'd1, '0, "R5 half upper");
    acc(WA, 0, 1, 2'd1, '0, "R5 half lower");
    acc(WA, 0, 1, 2'd2, '0, "R5 word");
    wr(1, 32'h0000_011F, "R5 setup");
    acc(WA + 2, 0, 1, 2'd1, '0, "R5 half lanes3:2");
    acc(WA + 3, 0, 1, 2'd0, '0, "R5 byte lane3");
    acc(WA + 1, 0, 1, 2'd0, '0, "R5 byte lane1");
    acc(WA + 1, 0, 1, 2'd3, '0, "R5 size3 word");

    wr(4, 32'h0000_005A, "R6 setup");
    wr(5, 32'h0000_0001, "R6 setup");
    wr(1, 32'h0011_01FF, "R6 setup");
    acc(WA, 0, 1, 2'd2, 8'h5A, "R6 ctx match");
    acc(WA, 0, 1, 2'd2, 8'h5B, "R6 ctx mismatch");
    wr(1, 32'h0010_01FF, "R6 setup");
    acc(WA, 0, 1, 2'd2, 8'h00, "R6 comparator0 disabled");
    wr(1, 32'h0011_01FF, "R6 setup");
    wr(5, 32'h0000_0000, "R6 setup");
    acc(WA, 0, 1, 2'd2, 8'h5A, "R6 linked comparator off");
    wr(5, 32'h0000_0001, "R6 setup");
    wr(1, 32'h0013_01FF, "R6 setup");
    acc(WA, 0, 1, 2'd2, 8'h5A, "R6 index 3 out of range");
    wr(1, 32'h001F_01FF, "R6 setup");
    acc(WA, 0, 1, 2'd2, 8'h00, "R6 index 15 out of range");

    wr(1, 32'h000F_01FF, "R7 setup");
    acc(WA, 0, 1, 2'd2, 8'hC3, "R7 no link any ctx");
    acc(WA, 1, 0, 2'd2, 8'h00, "R7 no link ctx zero");

    step(0, WA, 0, 1, 2'd2, '0, 0, 0, 32'h0, "R8 valid low");
    acc(WA, 0, 1, 2'd2, '0, "R8 back-to-back 1");
    acc(WA, 0, 1, 2'd2, '0, "R8 back-to-back 2");
    step(0, WA, 0, 1, 2'd2, '0, 0, 0, 32'h0, "R8 pulse ends");

    step(1, WA, 0, 1, 2'd2, '0, 1, 1, 32'h0000_01FE, "R9 access with disabling write");
    acc(WA, 0, 1, 2'd2, '0, "R9 after disable");
    step(1, WA, 0, 1, 2'd2, '0, 1, 1, 32'h0000_01FF, "R9 access with enabling write");
    acc(WA, 0, 1, 2'd2, '0, "R9 after enable");
    step(1, WA, 0, 1, 2'd2, '0, 1, 0, WA + 8, "R9 access with value write");
    acc(WA, 0, 1, 2'd2, '0, "R9 old address now");
    acc(WA + 8, 0, 1, 2'd2, '0, "R9 new address now");

    step(0, 32'h0, 0, 0, 2'd0, '0, 0, 0, 32'h0, "R8 flush");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule